// File: doc/BRIEF.md
# Speculative Register Poison Tracker

This block follows data-validity for a leading speculative instruction stream. The stream does not wait on a load that misses in the second-level cache. Instead, the load's destination register is marked poisoned. The poison then spreads: an instruction that reads a poisoned register poisons its own destination. An instruction that reads only clean registers, and is not itself a missing load, cleans its destination again.

Each instruction arrives in program order, one per cycle at most. The block reports, one cycle later, whether that instruction's result is poisoned, so that the result queue can store the flag next to the result. Stores write no register. A store with a poisoned data or address operand is reported as poisoned, and its write to the run-ahead cache is suppressed.

A rewind input clears every poison bit at once, so that the stream can restart from committed state. Register values, cache timing and the pipeline around the block are outside its scope.

Top module: `poison_tracker`

## Requirements
- R1: After a synchronous reset, ret_vld_o is 0 and every register reads as clean.
- R2: An issued instruction with l2_miss_i=1 is reported with ret_inv_o=1, and when it writes a destination, that register becomes poisoned.
- R3: An issued instruction is reported poisoned, and poisons its destination, when either used source (port A or port B) names a poisoned register.
- R4: An issued non-store instruction with dst_we_i=1, l2_miss_i=0 and all used sources clean is reported with ret_inv_o=0 and cleans its destination.
- R5: A source whose use flag is 0 has no effect on the verdict, even when it names a poisoned register.
- R6: A store (store_i=1) writes no register. It is reported with ret_st_wr_o=1 exactly when it is not poisoned; a poisoned store has ret_st_wr_o=0.
- R7: Writes to register 0 are ignored, so register 0 always reads as clean.
- R8: rewind_i=1 cleans all registers in that cycle. An instruction issued in the same cycle is dropped: it is not reported and does not write.
- R9: The verdict for an instruction issued in cycle N appears on ret_vld_o, ret_dst_o, ret_inv_o and ret_st_wr_o in cycle N+1. In a cycle that follows no issue, ret_vld_o is 0.
- R10: An instruction issued in the cycle right after a producer already sees the poison state that the producer wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rewind_i | input | 1 | Clears all poison bits and drops the instruction issued in the same cycle |
| issue_i | input | 1 | An instruction is present this cycle |
| src_a_i | input | IDX_W | Register index of source A |
| src_a_use_i | input | 1 | Source A is read |
| src_b_i | input | IDX_W | Register index of source B |
| src_b_use_i | input | 1 | Source B is read |
| dst_i | input | IDX_W | Destination register index |
| dst_we_i | input | 1 | Instruction writes dst_i |
| l2_miss_i | input | 1 | Instruction is a load that missed the second-level cache |
| store_i | input | 1 | Instruction is a store |
| ret_vld_o | output | 1 | A verdict is being reported |
| ret_dst_o | output | IDX_W | Destination of the reported instruction |
| ret_inv_o | output | 1 | The reported instruction is poisoned |
| ret_st_wr_o | output | 1 | The reported store may update the run-ahead cache |

## Verification
Every verdict is due exactly one cycle after issue. The only stage on the way is the output register, because the poison array is read combinationally. The bench drives each instruction between edges and samples one time unit after the next rising edge. The poison array is also updated at that edge, so the bench probes a register's state with an extra store that reads it, and checks that probe's verdict one cycle later. This checks back-to-back dependence, rewind and register 0 at the ports.

// File: rtl/poison_pkg.sv
package poison_pkg;
  parameter int unsigned PT_REGS = 32;

  typedef struct packed {
    logic inv;
    logic st_wr;
  } verdict_t;
endpackage

// File: rtl/poison_file.sv
module poison_file #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic [IDX_W-1:0] rd_a_i,
  input  logic [IDX_W-1:0] rd_b_i,
  output logic             rd_a_o,
  output logic             rd_b_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_val_i
);
  logic [NUM_REGS-1:0] bits_q;

  // Register 0 is never stored; all others keep one poison bit.
  assign bits_q[0] = 1'b0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        bits_q[g] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        bits_q[g] <= wr_val_i;
      end
    end
  end

  assign rd_a_o = bits_q[rd_a_i];
  assign rd_b_o = bits_q[rd_b_i];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (bits_q == '0)); // R8

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !clear_i && wr_idx_i != '0) |=> (bits_q[$past(wr_idx_i)] == $past(wr_val_i))); // R4

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_idx_i == '0) |=> (bits_q[0] == 1'b0)); // R7
endmodule

// File: rtl/poison_eval.sv
module poison_eval
  import poison_pkg::*;
(
  input  logic     src_a_bad_i,
  input  logic     src_a_use_i,
  input  logic     src_b_bad_i,
  input  logic     src_b_use_i,
  input  logic     l2_miss_i,
  input  logic     store_i,
  output verdict_t verdict_o
);
  logic inv;

  always_comb begin
    inv = l2_miss_i
        | (src_a_use_i & src_a_bad_i)
        | (src_b_use_i & src_b_bad_i);
    verdict_o.inv   = inv;
    verdict_o.st_wr = store_i & ~inv;
  end
endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
  import poison_pkg::*;
#(
  parameter int unsigned NUM_REGS = PT_REGS,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rewind_i,
  input  logic             issue_i,
  input  logic [IDX_W-1:0] src_a_i,
  input  logic             src_a_use_i,
  input  logic [IDX_W-1:0] src_b_i,
  input  logic             src_b_use_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic             dst_we_i,
  input  logic             l2_miss_i,
  input  logic             store_i,
  output logic             ret_vld_o,
  output logic [IDX_W-1:0] ret_dst_o,
  output logic             ret_inv_o,
  output logic             ret_st_wr_o
);
  logic     a_bad, b_bad;
  logic     accept;
  logic     wr_en;
  verdict_t verdict;

  assign accept = issue_i & ~rewind_i;
  assign wr_en  = accept & dst_we_i & ~store_i;

  poison_file #(.NUM_REGS(NUM_REGS)) u_file (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (rewind_i),
    .rd_a_i   (src_a_i),
    .rd_b_i   (src_b_i),
    .rd_a_o   (a_bad),
    .rd_b_o   (b_bad),
    .wr_en_i  (wr_en),
    .wr_idx_i (dst_i),
    .wr_val_i (verdict.inv)
  );

  poison_eval u_eval (
    .src_a_bad_i (a_bad),
    .src_a_use_i (src_a_use_i),
    .src_b_bad_i (b_bad),
    .src_b_use_i (src_b_use_i),
    .l2_miss_i   (l2_miss_i),
    .store_i     (store_i),
    .verdict_o   (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_vld_o   <= 1'b0;
      ret_dst_o   <= '0;
      ret_inv_o   <= 1'b0;
      ret_st_wr_o <= 1'b0;
    end else begin
      ret_vld_o   <= accept;
      ret_dst_o   <= accept ? dst_i : '0;
      ret_inv_o   <= accept & verdict.inv;
      ret_st_wr_o <= accept & verdict.st_wr;
    end
  end

  AST_MISS_POISONS: assert property (@(posedge clk) disable iff (rst)
    (accept && l2_miss_i) |=> ret_inv_o); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !ret_vld_o); // R9

  AST_STORE_GATED: assert property (@(posedge clk) disable iff (rst)
    ret_st_wr_o |-> (ret_vld_o && !ret_inv_o)); // R6

  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    store_i |-> !wr_en); // R6
endmodule

// File: tb/poison_tracker_bench.sv
module poison_tracker_bench;
  localparam int unsigned IDX_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rewind_i = 1'b0, issue_i = 1'b0;
  logic [IDX_W-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic src_a_use_i = 1'b0, src_b_use_i = 1'b0, dst_we_i = 1'b0;
  logic l2_miss_i = 1'b0, store_i = 1'b0;
  logic ret_vld_o, ret_inv_o, ret_st_wr_o;
  logic [IDX_W-1:0] ret_dst_o;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  poison_tracker u_poison_tracker (
    .clk(clk), .rst(rst), .rewind_i(rewind_i), .issue_i(issue_i),
    .src_a_i(src_a_i), .src_a_use_i(src_a_use_i),
    .src_b_i(src_b_i), .src_b_use_i(src_b_use_i),
    .dst_i(dst_i), .dst_we_i(dst_we_i), .l2_miss_i(l2_miss_i),
    .store_i(store_i), .ret_vld_o(ret_vld_o), .ret_dst_o(ret_dst_o),
    .ret_inv_o(ret_inv_o), .ret_st_wr_o(ret_st_wr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Issue one instruction; returns once its verdict is visible (one cycle later).
  task automatic issue(input int a, input bit ua, input int b, input bit ub,
                       input int d, input bit we, input bit miss, input bit st,
                       input bit rw);
    issue_i = 1'b1; src_a_i = IDX_W'(a); src_a_use_i = ua;
    src_b_i = IDX_W'(b); src_b_use_i = ub; dst_i = IDX_W'(d);
    dst_we_i = we; l2_miss_i = miss; store_i = st; rewind_i = rw;
    @(posedge clk); #1;
    issue_i = 1'b0; rewind_i = 1'b0; l2_miss_i = 1'b0; store_i = 1'b0;
    dst_we_i = 1'b0; src_a_use_i = 1'b0; src_b_use_i = 1'b0;
  endtask

  // Read the poison bit of register r through a store probe.
  task automatic probe(input string req, input int r, input bit exp_bad);
    issue(r, 1, 0, 0, 0, 0, 0, 1, 0);
    chk(req, $sformatf("probe r%0d inv", r), ret_inv_o, exp_bad);
    chk(req, $sformatf("probe r%0d st_wr", r), ret_st_wr_o, !exp_bad);
  endtask

  task automatic t_reset;
    chk("R1", "vld after reset", ret_vld_o, 0);
    for (int r = 0; r < 32; r += 7) probe("R1", r, 0);
  endtask

  task automatic t_miss;
    issue(0, 0, 0, 0, 5, 1, 1, 0, 0);
    chk("R2", "miss vld", ret_vld_o, 1);
    chk("R2", "miss inv", ret_inv_o, 1);
    chk("R9", "miss dst", ret_dst_o, 5);
    probe("R2", 5, 1);
  endtask

  task automatic t_propagate;
    issue(5, 1, 0, 0, 6, 1, 0, 0, 0);   // port A reads poisoned r5
    chk("R3", "port A inv", ret_inv_o, 1);
    issue(1, 1, 6, 1, 7, 1, 0, 0, 0);   // port B reads poisoned r6
    chk("R3", "port B inv", ret_inv_o, 1);
    probe("R3", 6, 1);
    probe("R3", 7, 1);
  endtask

  task automatic t_clean;
    issue(1, 1, 2, 1, 6, 1, 0, 0, 0);
    chk("R4", "clean inv", ret_inv_o, 0);
    probe("R4", 6, 0);
  endtask

  task automatic t_unused;
    issue(5, 0, 7, 0, 8, 1, 0, 0, 0);
    chk("R5", "unused srcs inv", ret_inv_o, 0);
    probe("R5", 8, 0);
  endtask

  task automatic t_store;
    issue(3, 1, 5, 1, 9, 1, 0, 1, 0);   // store with poisoned operand, dst 9 ignored
    chk("R6", "bad store inv", ret_inv_o, 1);
    chk("R6", "bad store st_wr", ret_st_wr_o, 0);
    issue(0, 0, 0, 0, 9, 1, 1, 0, 0);   // poison r9
    issue(1, 1, 2, 1, 9, 1, 0, 1, 0);   // clean store must not clean r9
    chk("R6", "good store st_wr", ret_st_wr_o, 1);
    probe("R6", 9, 1);
  endtask

  task automatic t_zero;
    issue(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R7", "r0 miss inv", ret_inv_o, 1);
    probe("R7", 0, 0);
  endtask

  task automatic t_b2b;
    issue(0, 0, 0, 0, 12, 1, 1, 0, 0);
    issue(12, 1, 0, 0, 13, 1, 0, 0, 0);
    chk("R10", "next-cycle consumer", ret_inv_o, 1);
    issue(1, 1, 0, 0, 13, 1, 0, 0, 0);
    issue(13, 1, 0, 0, 14, 1, 0, 0, 0);
    chk("R10", "next-cycle clean", ret_inv_o, 0);
  endtask

  task automatic t_rewind;
    issue(0, 0, 0, 0, 20, 1, 1, 0, 1);  // dropped
    chk("R8", "dropped vld", ret_vld_o, 0);
    chk("R9", "idle vld", ret_vld_o, 0);
    probe("R8", 5, 0);
    probe("R8", 9, 0);
    probe("R8", 20, 0);
    probe("R8", 12, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_miss();
    t_propagate();
    t_clean();
    t_unused();
    t_store();
    t_zero();
    t_b2b();
    t_rewind();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule